// File: doc/BRIEF.md
# Programmable Power-of-Two Clock Divider

This block takes one input clock and drives a frequency-locked output clock. A three-bit select picks the mode. One mode passes the input straight through. The other four divide it by 2, 4, 8 or 16.

The output appears on two identical copies, and each copy comes with a complementary partner. All outputs are modelled as ordinary logic signals.

An active-low control input has two roles, depending on the mode:
- In the divide modes it clears the divider counter asynchronously and forces the outputs to their idle levels.
- In pass-through mode it acts as an output enable. The enable is sampled on the falling edge of the input clock, so a high phase of the output is never cut short.

A typical use derives a slower auxiliary clock from a fast line clock, for example a 622 MHz input giving roughly 311, 155, 77 or 38 MHz.

Top module: `pow2_clk_divider`

## Requirements
- R1: With `modeSel[2]` = 0 the output follows the input clock while enabled, whatever the values of `modeSel[1:0]`.
- R2: With `modeSel[2]` = 1, the code in `modeSel[1:0]` sets the divide ratio N: 00 gives N = 2, 01 gives N = 4, 10 gives N = 8 and 11 gives N = 16. The output stays high for N/2 input rising edges and then low for N/2.
- R3: In a divide mode, `rstN` low clears the divider at once, without waiting for a clock edge. While `rstN` stays low, `clkOut` is all zeros and `clkOutN` is all ones.
- R4: After `rstN` is released in a divide mode, the output first rises on the N/2-th rising edge of the input clock.
- R5: In pass-through mode, a change on `rstN` takes effect only at the next falling edge of the input clock. Low disables the output and high enables it.
- R6: In pass-through mode, a change on the enable never truncates a high phase in progress. It also never produces a partial pulse.
- R7: Both copies of `clkOut` are always equal, and each bit of `clkOutN` is always the inverse of the matching bit of `clkOut`. This holds while the output is disabled as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Input clock |
| rstN | input | 1 | Active-low divider clear (divide modes) or output enable (pass-through mode) |
| modeSel | input | 3 | Bit 2 picks divide (1) or pass-through (0); bits 1:0 pick the ratio |
| clkOut | output | 2 | Output clock copies |
| clkOutN | output | 2 | Complement of each output clock copy |

## Verification
The bench counts half periods of the input clock and samples 5 ns after every input edge.

**Divide modes.** The counter advances on each rising edge, so the expected output in half period m after release is bit log2(N)-1 of ceil(m/2). The driver queues that value for every half period it predicts.

**Pass-through mode.** An enable change shows up only in the half period after the next falling edge. The expected items are therefore placed one or two half periods after the stimulus.

**Asynchronous clear and high-phase retention.** These are checked 1 ns after the input changes, well before the next clock edge can be involved.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int TAP_COUNT = 4;

  typedef struct packed {
    logic                 passMode;
    logic                 outEnable;
    logic [TAP_COUNT-1:0] tapHot;
  } divStrobe_t;
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clkIn,
  input  logic             rstN,
  input  logic [SEL_W-1:0] modeSel,
  output divStrobe_t       strb
);
  logic enableFf;

  // enable flop: sampled while the input clock is low-going
  always_ff @(negedge clkIn) begin
    enableFf <= rstN;
  end

  genvar t;
  generate
    for (t = 0; t < TAP_COUNT; t++) begin : gTapDecode
      assign strb.tapHot[t] = modeSel[SEL_W-1] &&
                              (modeSel[SEL_W-2:0] == (SEL_W-1)'(t));
    end
  endgenerate

  assign strb.passMode  = ~modeSel[SEL_W-1];
  assign strb.outEnable = enableFf;

  assert_tap_onehot_R2: assert property (@(posedge clkIn) disable iff (!rstN)
    $onehot0(strb.tapHot) && (strb.passMode == (strb.tapHot == '0)))
    else $error("tap decode not one-hot in divide mode");
endmodule

// File: rtl/clkdiv_dp.sv
module clkdiv_dp
  import clkdiv_pkg::*;
#(
  parameter int COPIES = 2
) (
  input  logic              clkIn,
  input  logic              rstN,
  input  divStrobe_t        strb,
  output logic [COPIES-1:0] clkOut,
  output logic [COPIES-1:0] clkOutN
);
  logic [TAP_COUNT-1:0] divCount;
  logic                 divOut;
  logic                 passOut;
  logic                 selOut;

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) divCount <= '0;
    else       divCount <= divCount + 1'b1;
  end

  assign divOut  = |(divCount & strb.tapHot);
  assign passOut = clkIn & strb.outEnable;
  assign selOut  = strb.passMode ? passOut : divOut;

  genvar c;
  generate
    for (c = 0; c < COPIES; c++) begin : gFanout
      assign clkOut[c]  = selOut;
      assign clkOutN[c] = ~selOut;
    end
  endgenerate

  assert_div2_toggle_R2: assert property (@(posedge clkIn) disable iff (!rstN)
    (!strb.passMode && strb.tapHot == 4'b0001) |=>
      (!$stable(strb) || divOut != $past(divOut)))
    else $error("divide-by-2 output failed to toggle");

  assert_pass_gate_R6: assert property (@(negedge clkIn)
    strb.passMode |-> (clkOut == {COPIES{strb.outEnable}}))
    else $error("pass-through high phase altered before falling edge");
endmodule

// File: rtl/pow2_clk_divider.sv
module pow2_clk_divider
  import clkdiv_pkg::*;
#(
  parameter int COPIES = 2,
  parameter int SEL_W  = 3
) (
  input  logic              clkIn,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  modeSel,
  output logic [COPIES-1:0] clkOut,
  output logic [COPIES-1:0] clkOutN
);
  divStrobe_t strb;

  clkdiv_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clkIn   (clkIn),
    .rstN    (rstN),
    .modeSel (modeSel),
    .strb    (strb)
  );

  clkdiv_dp #(.COPIES(COPIES)) u_dp (
    .clkIn   (clkIn),
    .rstN    (rstN),
    .strb    (strb),
    .clkOut  (clkOut),
    .clkOutN (clkOutN)
  );

  assert_reset_low_R3: assert property (@(posedge clkIn)
    (!rstN && modeSel[SEL_W-1]) |-> (clkOut == '0 && clkOutN == '1))
    else $error("outputs not idle while divider cleared");
endmodule

// File: tb/pow2_clk_divider_bench.sv
`timescale 1ns/1ps
module pow2_clk_divider_bench;
  localparam int COPIES = 2;

  logic              clkIn;
  logic              rstN;
  logic [2:0]        modeSel;
  logic [COPIES-1:0] clkOut;
  logic [COPIES-1:0] clkOutN;

  pow2_clk_divider #(.COPIES(COPIES), .SEL_W(3)) u_pow2_clk_divider (
    .clkIn   (clkIn),
    .rstN    (rstN),
    .modeSel (modeSel),
    .clkOut  (clkOut),
    .clkOutN (clkOutN)
  );

  typedef struct {
    int    at;
    bit    val;
    string req;
  } sbItem_t;

  sbItem_t sbQ[$];
  int halfCount = 0;
  int checks    = 0;
  int errors    = 0;
  bit done      = 0;

  initial begin
    clkIn = 0;
    forever #10 clkIn = ~clkIn;
  end

  function automatic logic [2*COPIES-1:0] expVec(bit v);
    return {{COPIES{v}}, {COPIES{~v}}};
  endfunction

  task automatic check(bit ok, string req, logic [2*COPIES-1:0] act,
                       logic [2*COPIES-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pushExp(int at, bit v, string req);
    sbItem_t it;
    it.at = at; it.val = v; it.req = req;
    sbQ.push_back(it);
  endtask

  task automatic drain();
    while (sbQ.size() != 0) @(posedge clkIn);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: one sample per half period, 5 ns after each input edge
  initial begin
    forever begin
      @(clkIn);
      #5;
      halfCount++;
      while (sbQ.size() != 0 && sbQ[0].at <= halfCount) begin
        sbItem_t it;
        it = sbQ.pop_front();
        check(it.at == halfCount && {clkOut, clkOutN} == expVec(it.val),
              it.req, {clkOut, clkOutN}, expVec(it.val));
      end
    end
  end

  // divide mode k selects N = 2^(k+1)
  task automatic divTest(int k);
    int h;
    @(negedge clkIn); #6;
    modeSel = {1'b1, 2'(k)};
    rstN = 0;
    h = halfCount;
    for (int m = 1; m <= 4; m++) pushExp(h + m, 1'b0, "R3");
    drain();
    @(negedge clkIn); #6;
    h = halfCount;
    rstN = 1;
    for (int m = 1; m <= 4 * (2 << k); m++) begin
      int j;
      j = (m + 1) / 2;
      pushExp(h + m, bit'((j >> k) & 1), (m <= (2 << k)) ? "R4" : "R2");
    end
    drain();
  endtask

  task automatic asyncClearTest();
    @(negedge clkIn); #6;
    modeSel = 3'b111;
    rstN = 0;
    @(negedge clkIn); #6;
    rstN = 1;
    repeat (10) @(posedge clkIn);
    #6;
    check(clkOut == '1, "R2", {clkOut, clkOutN}, expVec(1'b1));
    rstN = 0;
    #1;
    check(clkOut == '0 && clkOutN == '1, "R3", {clkOut, clkOutN}, expVec(1'b0));
    @(negedge clkIn); #6;
    rstN = 1;
  endtask

  task automatic passTest(logic [1:0] lowBits);
    int h;
    @(negedge clkIn); #6;
    modeSel = {1'b0, lowBits};
    rstN = 1;
    @(negedge clkIn); #6;
    h = halfCount;
    rstN = 0;
    pushExp(h + 1, 1'b1, "R5");
    pushExp(h + 2, 1'b0, "R5");
    pushExp(h + 3, 1'b0, "R7");
    pushExp(h + 4, 1'b0, "R7");
    drain();
    @(negedge clkIn); #6;
    h = halfCount;
    rstN = 1;
    pushExp(h + 1, 1'b0, "R5");
    pushExp(h + 2, 1'b0, "R5");
    pushExp(h + 3, 1'b1, "R1");
    pushExp(h + 4, 1'b0, "R1");
    pushExp(h + 5, 1'b1, "R1");
    pushExp(h + 6, 1'b0, "R1");
    drain();
  endtask

  task automatic highPhaseTest();
    int p;
    @(negedge clkIn); #6;
    modeSel = 3'b010;
    rstN = 1;
    @(posedge clkIn); #6;
    p = halfCount;
    rstN = 0;
    #1;
    check(clkOut == '1 && clkOutN == '0, "R6", {clkOut, clkOutN}, expVec(1'b1));
    pushExp(p + 1, 1'b0, "R6");
    pushExp(p + 2, 1'b0, "R6");
    drain();
    @(posedge clkIn); #6;
    p = halfCount;
    rstN = 1;
    #1;
    check(clkOut == '0 && clkOutN == '1, "R6", {clkOut, clkOutN}, expVec(1'b0));
    pushExp(p + 1, 1'b0, "R5");
    pushExp(p + 2, 1'b1, "R5");
    drain();
  endtask

  initial begin
    rstN = 0;
    modeSel = 3'b101;
    repeat (3) @(posedge clkIn);
    #6;
    check(clkOut == '0 && clkOutN == '1, "R3", {clkOut, clkOutN}, expVec(1'b0));
    for (int k = 0; k < 4; k++) divTest(k);
    asyncClearTest();
    passTest(2'b00);
    passTest(2'b11);
    highPhaseTest();
    divTest(1);
    repeat (2) @(posedge clkIn);
    finishRun();
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule